// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block is a small shared word memory placed behind one arbitrated access port. Several requesters present requests in parallel. Each request names the requester by its slot position and carries an operation code, a word address and two operands. A round-robin arbiter picks one request per cycle. The chosen operation reads the addressed word, computes the new value and writes it back on the same clock edge, so no other access can fall between the read and the write of an atomic operation.

Besides plain loads and stores, the unit offers the usual synchronisation primitives: test-and-set, exchange, fetch-and-increment, fetch-and-decrement, fetch-and-add, compare-and-swap, and a linked load paired with a conditional store. For each word the unit keeps one reservation entry (a valid bit and the owning requester) that decides whether a conditional store succeeds. Every response returns the value the word held before the operation, together with a success flag, one cycle after the grant. Software locks follow the convention that 0 means free and 1 means held.

Top module: `amo_unit`

## Requirements
- R1: Requester i drives slot i of each packed request vector (opcode bits [4i+3:4i], address, operand A and operand B slices likewise). At most one grant is high per cycle, and only for a requester whose valid is high. Priority rotates: after requester i is granted, the search starts at i+1, so every requester that holds valid is granted within NREQ cycles.
- R2: rsp_valid is high exactly in the cycle after a grant. In that cycle rsp_id equals the granted requester and rsp_data equals the word's value before the operation.
- R3: Opcode 0 (load) leaves memory unchanged and opcode 1 (store) writes operand A. Both report ok=1.
- R4: Opcode 2 (test-and-set) writes 1. It reports ok=1 only if the old value was 0, meaning the lock was acquired.
- R5: Opcode 3 (exchange) writes operand A and returns the old word with ok=1. A returned 0 means a lock was acquired.
- R6: Opcodes 4, 5 and 6 write old+1, old-1 and old+operand A, wrapping modulo 2^DW, with ok=1.
- R7: Opcode 7 (compare-and-swap) writes operand B and reports ok=1 only when the old word equals operand A. Otherwise the word is unchanged and ok=0.
- R8: Opcode 8 (linked load) returns the word with ok=1 and records the requester as the word's reservation owner. A later linked load to the same word by any requester replaces that owner.
- R9: Opcode 9 (conditional store) writes operand A and reports ok=1 only when the word holds a valid reservation owned by the same requester. Otherwise the word is unchanged and ok=0.
- R10: Any write to a word clears that word's reservation. This covers stores, atomic operations and successful conditional stores.
- R11: Atomic operations granted in consecutive cycles to the same word are serialised: each one sees the result written by the one before it.
- R12: After reset every word is 0, no reservation is valid and rsp_valid is low.
- R13: Opcodes 10 to 15 write nothing, leave reservations unchanged and report ok=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_op | input | 4*NREQ | Operation code per requester |
| req_addr | input | AW*NREQ | Word address per requester |
| req_opa | input | DW*NREQ | Operand A per requester |
| req_opb | input | DW*NREQ | Operand B per requester |
| req_grant | output | NREQ | One-hot grant, combinational in the request cycle |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | IDW | Requester the response belongs to |
| rsp_data | output | DW | Word value before the operation |
| rsp_ok | output | 1 | Success flag |

## Verification
Each primitive is driven twice, once with operands that make it succeed and once with operands that make it fail: test-and-set on a free word and on a held word, compare-and-swap with a matching and with a stale expected value, and conditional stores after an own reservation, after a reservation taken over by another requester, and after an intervening write. Fetch operations are tried at the wrap points 0xFFFFFFFF and 0, which exposes carry and borrow mistakes. All four requesters are raised together to check that the rotation grants each one exactly once. Two simultaneous increments of one word are checked to produce two distinct old values and a final sum, which would expose a lost update.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_LOAD  = 4'd0;
  localparam logic [OPW-1:0] OP_STORE = 4'd1;
  localparam logic [OPW-1:0] OP_TAS   = 4'd2;
  localparam logic [OPW-1:0] OP_SWAP  = 4'd3;
  localparam logic [OPW-1:0] OP_FINC  = 4'd4;
  localparam logic [OPW-1:0] OP_FDEC  = 4'd5;
  localparam logic [OPW-1:0] OP_FADD  = 4'd6;
  localparam logic [OPW-1:0] OP_CAS   = 4'd7;
  localparam logic [OPW-1:0] OP_LL    = 4'd8;
  localparam logic [OPW-1:0] OP_SC    = 4'd9;

  // true for opcodes 10..15, which do nothing
  function automatic logic op_unknown(input logic [OPW-1:0] op);
    return op > OP_SC;
  endfunction
endpackage

// File: rtl/amo_arbiter.sv
module amo_arbiter #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] ptr_d;

  function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] base, input int off);
    int s;
    s = int'(base) + off;
    if (s >= N) s = s - N;
    return IW'(s);
  endfunction

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int off = 0; off < N; off++) begin
      if (!gnt_any && req[wrap_add(ptr_q, off)]) begin
        gnt_any                  = 1'b1;
        gnt_idx                  = wrap_add(ptr_q, off);
        gnt[wrap_add(ptr_q, off)] = 1'b1;
      end
    end
    ptr_d = wrap_add(gnt_idx, 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (gnt_any) ptr_q <= ptr_d;
  end

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_grant_requested_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  assert_grant_when_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> gnt_any);
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  old_val,
  input  logic [DW-1:0]  opa,
  input  logic [DW-1:0]  opb,
  input  logic           resv_hit,
  output logic           wr_en,
  output logic [DW-1:0]  wr_val,
  output logic           ok
);
  localparam logic [DW-1:0] ONE = DW'(1);

  function automatic logic [DW-1:0] fetch_result(input logic [OPW-1:0] f_op,
                                                  input logic [DW-1:0] v,
                                                  input logic [DW-1:0] addend);
    case (f_op)
      OP_FINC: return v + ONE;
      OP_FDEC: return v - ONE;
      default: return v + addend;
    endcase
  endfunction

  always_comb begin
    wr_en  = 1'b0;
    wr_val = opa;
    ok     = 1'b1;
    case (op)
      OP_LOAD, OP_LL: ;
      OP_STORE, OP_SWAP: wr_en = 1'b1;
      OP_TAS: begin
        wr_en  = 1'b1;
        wr_val = ONE;
        ok     = (old_val == '0);
      end
      OP_FINC, OP_FDEC, OP_FADD: begin
        wr_en  = 1'b1;
        wr_val = fetch_result(op, old_val, opa);
      end
      OP_CAS: begin
        wr_en  = (old_val == opa);
        wr_val = opb;
        ok     = (old_val == opa);
      end
      OP_SC: begin
        wr_en = resv_hit;
        ok    = resv_hit;
      end
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int IDW   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_en,
  input  logic [AW-1:0]  set_addr,
  input  logic [IDW-1:0] set_id,
  input  logic           clr_en,
  input  logic [AW-1:0]  clr_addr,
  input  logic [AW-1:0]  chk_addr,
  input  logic [IDW-1:0] chk_id,
  output logic           hit
);
  logic [DEPTH-1:0] valid_q;
  logic [IDW-1:0]   owner_q [DEPTH];

  assign hit = valid_q[chk_addr] && (owner_q[chk_addr] == chk_id);

  for (genvar w = 0; w < DEPTH; w++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[w] <= 1'b0;
        owner_q[w] <= '0;
      end else if (set_en && set_addr == AW'(w)) begin
        valid_q[w] <= 1'b1;
        owner_q[w] <= set_id;
      end else if (clr_en && clr_addr == AW'(w)) begin
        valid_q[w] <= 1'b0;
      end
    end
  end

  assert_write_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> !valid_q[$past(clr_addr)]);
  assert_link_records_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (valid_q[$past(set_addr)] && owner_q[$past(set_addr)] == $past(set_id)));
endmodule

// File: rtl/amo_mem.sv
module amo_mem #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] word_q [DEPTH];

  assign rd_data = word_q[rd_addr];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                           word_q[w] <= '0;
      else if (wr_en && wr_addr == AW'(w))  word_q[w] <= wr_data;
    end
  end

  assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (word_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int DW   = 32,
  parameter int AW   = 4,
  localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREQ-1:0]     req_valid,
  input  logic [NREQ*4-1:0]   req_op,
  input  logic [NREQ*AW-1:0]  req_addr,
  input  logic [NREQ*DW-1:0]  req_opa,
  input  logic [NREQ*DW-1:0]  req_opb,
  output logic [NREQ-1:0]     req_grant,
  output logic                rsp_valid,
  output logic [IDW-1:0]      rsp_id,
  output logic [DW-1:0]       rsp_data,
  output logic                rsp_ok
);
  localparam int DEPTH = 1 << AW;

  // named internal events
  logic [IDW-1:0] gnt_idx;
  logic           gnt_any;
  logic [OPW-1:0] sel_op;
  logic [AW-1:0]  sel_addr;
  logic [DW-1:0]  sel_opa;
  logic [DW-1:0]  sel_opb;
  logic [DW-1:0]  old_val;
  logic           resv_hit;
  logic           alu_we;
  logic [DW-1:0]  alu_val;
  logic           alu_ok;
  logic           mem_we;
  logic           link_set;

  amo_arbiter #(.N(NREQ)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid),
    .gnt(req_grant), .gnt_idx(gnt_idx), .gnt_any(gnt_any)
  );

  assign sel_op   = req_op[gnt_idx*OPW +: OPW];
  assign sel_addr = req_addr[gnt_idx*AW +: AW];
  assign sel_opa  = req_opa[gnt_idx*DW +: DW];
  assign sel_opb  = req_opb[gnt_idx*DW +: DW];

  amo_mem #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .rd_addr(sel_addr), .rd_data(old_val),
    .wr_en(mem_we), .wr_addr(sel_addr), .wr_data(alu_val)
  );

  amo_alu #(.DW(DW)) u_alu (
    .op(sel_op), .old_val(old_val), .opa(sel_opa), .opb(sel_opb),
    .resv_hit(resv_hit), .wr_en(alu_we), .wr_val(alu_val), .ok(alu_ok)
  );

  assign mem_we   = gnt_any && alu_we;
  assign link_set = gnt_any && (sel_op == OP_LL);

  amo_resv #(.DEPTH(DEPTH), .AW(AW), .IDW(IDW)) u_resv (
    .clk(clk), .rst_n(rst_n),
    .set_en(link_set), .set_addr(sel_addr), .set_id(gnt_idx),
    .clr_en(mem_we), .clr_addr(sel_addr),
    .chk_addr(sel_addr), .chk_id(gnt_idx), .hit(resv_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_data  <= '0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= gnt_any;
      if (gnt_any) begin
        rsp_id   <= gnt_idx;
        rsp_data <= old_val;
        rsp_ok   <= alu_ok;
      end
    end
  end

  assert_rsp_follows_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_any |=> (rsp_valid && rsp_id == $past(gnt_idx)));
  assert_no_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_any |=> !rsp_valid);
  assert_sc_miss_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_any && sel_op == OP_SC && !resv_hit) |-> !mem_we);
  assert_cas_miss_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_any && sel_op == OP_CAS && old_val != sel_opa) |=> (!rsp_ok && rsp_data == $past(old_val)));
  assert_unknown_inert_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_any && op_unknown(sel_op)) |-> (!mem_we && !link_set));
endmodule

// File: tb/amo_unit_bench.sv
`timescale 1ns/1ps
module amo_unit_bench;
  localparam int NREQ = 4;
  localparam int DW   = 32;
  localparam int AW   = 4;
  localparam int IDW  = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [NREQ-1:0]    req_valid;
  logic [NREQ*4-1:0]  req_op;
  logic [NREQ*AW-1:0] req_addr;
  logic [NREQ*DW-1:0] req_opa;
  logic [NREQ*DW-1:0] req_opb;
  logic [NREQ-1:0]    req_grant;
  logic               rsp_valid;
  logic [IDW-1:0]     rsp_id;
  logic [DW-1:0]      rsp_data;
  logic               rsp_ok;

  int total = 0;
  int bad   = 0;

  // independent model state
  logic [DW-1:0] mm [1<<AW];
  logic          rv [1<<AW];
  int            rown [1<<AW];

  always #2 clk = ~clk;

  amo_unit #(.NREQ(NREQ), .DW(DW), .AW(AW)) u_amo_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
    .req_grant(req_grant), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .rsp_data(rsp_data), .rsp_ok(rsp_ok)
  );

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void model(input int id, input logic [3:0] op, input int a,
                                input logic [DW-1:0] x, input logic [DW-1:0] y,
                                output logic [DW-1:0] d, output logic ok);
    logic [DW-1:0] old;
    logic          w;
    logic [DW-1:0] nv;
    old = mm[a]; d = old; ok = 1'b1; w = 1'b0; nv = '0;
    case (op)
      4'd0: ;
      4'd1, 4'd3: begin w = 1'b1; nv = x; end
      4'd2: begin w = 1'b1; nv = 1; ok = (old == 0); end
      4'd4: begin w = 1'b1; nv = old + 1; end
      4'd5: begin w = 1'b1; nv = old - 1; end
      4'd6: begin w = 1'b1; nv = old + x; end
      4'd7: if (old == x) begin w = 1'b1; nv = y; end else ok = 1'b0;
      4'd8: begin rv[a] = 1'b1; rown[a] = id; end
      4'd9: if (rv[a] && rown[a] == id) begin w = 1'b1; nv = x; end else ok = 1'b0;
      default: ok = 1'b0;
    endcase
    if (w) begin mm[a] = nv; rv[a] = 1'b0; end
  endfunction

  task automatic drive(input int id, input logic [3:0] op, input int a,
                       input logic [DW-1:0] x, input logic [DW-1:0] y);
    req_op[id*4 +: 4]    = op;
    req_addr[id*AW +: AW] = AW'(a);
    req_opa[id*DW +: DW] = x;
    req_opb[id*DW +: DW] = y;
    req_valid[id]        = 1'b1;
  endtask

  task automatic run_op(input string req, input int id, input logic [3:0] op, input int a,
                        input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic [DW-1:0] ed;
    logic          eok;
    model(id, op, a, x, y, ed, eok);
    @(negedge clk);
    drive(id, op, a, x, y);
    #1 chk("R1", "grant", DW'(req_grant), DW'(1 << id));
    @(negedge clk);
    req_valid[id] = 1'b0;
    chk("R2", "rsp_valid", DW'(rsp_valid), 1);
    chk("R2", "rsp_id", DW'(rsp_id), DW'(id));
    chk(req, "rsp_data", rsp_data, ed);
    chk(req, "rsp_ok", DW'(rsp_ok), DW'(eok));
  endtask

  task automatic t_reset;
    chk("R12", "rsp_valid after reset", DW'(rsp_valid), 0);
    run_op("R12", 0, 4'd0, 5, 0, 0);
    run_op("R12", 1, 4'd9, 5, 32'h55, 0);   // no reservation exists
    run_op("R12", 1, 4'd0, 5, 0, 0);
  endtask

  task automatic t_load_store;
    run_op("R3", 2, 4'd1, 3, 32'hCAFE_0001, 0);
    run_op("R3", 0, 4'd0, 3, 0, 0);
    run_op("R3", 1, 4'd1, 3, 32'h1234_5678, 0);
    run_op("R3", 3, 4'd0, 3, 0, 0);
  endtask

  task automatic t_tas;
    run_op("R4", 0, 4'd2, 7, 0, 0);   // free: acquired
    run_op("R4", 1, 4'd2, 7, 0, 0);   // held: fails
    run_op("R4", 1, 4'd1, 7, 0, 0);   // release
    run_op("R4", 1, 4'd2, 7, 0, 0);
  endtask

  task automatic t_swap;
    run_op("R5", 2, 4'd3, 8, 1, 0);   // returns 0: lock taken
    run_op("R5", 3, 4'd3, 8, 1, 0);   // returns 1: held
    run_op("R5", 2, 4'd3, 8, 32'hABCD, 0);
    run_op("R5", 0, 4'd0, 8, 0, 0);
  endtask

  task automatic t_fetch;
    run_op("R6", 0, 4'd1, 9, 32'hFFFF_FFFF, 0);
    run_op("R6", 1, 4'd4, 9, 0, 0);   // wraps to 0
    run_op("R6", 2, 4'd5, 9, 0, 0);   // borrows to all ones
    run_op("R6", 3, 4'd6, 9, 32'h10, 0);
    run_op("R6", 0, 4'd6, 9, 32'h7000_0000, 0);
    run_op("R6", 0, 4'd0, 9, 0, 0);
  endtask

  task automatic t_cas;
    run_op("R7", 0, 4'd1, 10, 32'h40, 0);
    run_op("R7", 1, 4'd7, 10, 32'h41, 32'h99);  // stale: no write
    run_op("R7", 1, 4'd0, 10, 0, 0);
    run_op("R7", 2, 4'd7, 10, 32'h40, 32'h99);  // match
    run_op("R7", 2, 4'd0, 10, 0, 0);
  endtask

  task automatic t_llsc;
    run_op("R8", 1, 4'd8, 11, 0, 0);
    run_op("R9", 2, 4'd9, 11, 32'h22, 0);        // other owner: fails
    run_op("R9", 1, 4'd9, 11, 32'h11, 0);        // owner: succeeds
    run_op("R10", 1, 4'd9, 11, 32'h33, 0);       // cleared by own SC
    run_op("R8", 0, 4'd8, 11, 0, 0);
    run_op("R8", 2, 4'd8, 11, 0, 0);             // replaces owner
    run_op("R8", 0, 4'd9, 11, 32'h44, 0);        // old owner fails
    run_op("R9", 2, 4'd9, 11, 32'h55, 0);
    run_op("R8", 3, 4'd8, 12, 0, 0);
    run_op("R10", 0, 4'd1, 12, 32'h66, 0);       // store clears
    run_op("R10", 3, 4'd9, 12, 32'h77, 0);
    run_op("R8", 3, 4'd8, 12, 0, 0);
    run_op("R10", 1, 4'd4, 12, 0, 0);            // fetch-inc clears
    run_op("R10", 3, 4'd9, 12, 32'h88, 0);
    run_op("R10", 3, 4'd0, 12, 0, 0);
  endtask

  task automatic t_unknown;
    run_op("R13", 2, 4'd8, 13, 0, 0);
    run_op("R13", 0, 4'd12, 13, 32'h5, 32'h6);
    run_op("R13", 1, 4'd15, 13, 32'h5, 32'h6);
    run_op("R13", 2, 4'd9, 13, 32'hBEEF, 0);     // reservation survived
    run_op("R13", 2, 4'd0, 13, 0, 0);
  endtask

  task automatic t_arb;
    logic [NREQ-1:0] seen;
    logic [NREQ-1:0] g;
    seen = '0;
    @(negedge clk);
    for (int i = 0; i < NREQ; i++) drive(i, 4'd0, 2, 0, 0);
    for (int k = 0; k < NREQ; k++) begin
      #1;
      g = req_grant;
      chk("R1", "grant onehot", DW'($countones(g)), 1);
      chk("R1", "grant new requester", DW'(g & seen), 0);
      seen = seen | g;
      @(negedge clk);
      req_valid = req_valid & ~g;
      chk("R2", "rsp_valid", DW'(rsp_valid), 1);
      chk("R2", "rsp_id matches grant", DW'(1 << rsp_id), DW'(g));
    end
    chk("R1", "all granted", DW'(seen), DW'({NREQ{1'b1}}));
  endtask

  task automatic t_contend;
    logic [DW-1:0] v;
    logic [NREQ-1:0] g;
    logic [DW-1:0] r0;
    logic [DW-1:0] r1;
    v = mm[9];
    @(negedge clk);
    drive(1, 4'd4, 9, 0, 0);
    drive(3, 4'd4, 9, 0, 0);
    #1 g = req_grant;
    @(negedge clk);
    req_valid = req_valid & ~g;
    r0 = rsp_data;
    #1 chk("R1", "second requester granted", DW'($countones(req_grant)), 1);
    @(negedge clk);
    req_valid = '0;
    r1 = rsp_data;
    mm[9] = v + 2;
    rv[9] = 1'b0;
    chk("R11", "first old value", r0, v);
    chk("R11", "second old value", r1, v + 1);
    run_op("R11", 0, 4'd0, 9, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin mm[i] = '0; rv[i] = 1'b0; rown[i] = 0; end
    rst_n = 1'b0; req_valid = '0; req_op = '0; req_addr = '0; req_opa = '0; req_opb = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_load_store;
    t_tas;
    t_swap;
    t_fetch;
    t_cas;
    t_llsc;
    t_unknown;
    t_arb;
    t_contend;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule